// File: doc/BRIEF.md
# Storage Register with Selectable Asynchronous Clear, Preset and Load

This block is a register of parameterised width. Its asynchronous behaviour is fixed at build time by a three-bit mode parameter. Two active-low control lines, `ctrl1_n` and `ctrl2_n`, drive the asynchronous functions. The meaning of each line depends on the mode: it can force the register to zero, force it to all ones, or copy a separate load word into it at once, without waiting for a clock edge.

When no asynchronous function is active, the register is an ordinary edge-triggered store with a clock enable. Any clear or preset that a mode does not use is tied inactive, so the unused control line has no effect. A second parameter names the line that acts as the single control in the clear-only and preset-only modes.

Internally the block has three parts. A decoder turns the mode, the line choice and the two control pins into three active-low internal lines: clear, preset and load. Each bit of the register is a separate cell, and the cells are replicated across the width. Each cell applies its controls in a fixed priority: clear, then preset, then load, then the clocked path.

Top module: `async_ctl_reg`

## Requirements
- R1: With MODE 0 (clear only) and CTRL2_IS_CLR = 0, `ctrl1_n` low sets `q` to all zeros without a clock edge. `ctrl2_n` has no effect.
- R2: With CTRL2_IS_CLR = 1, the single control of MODE 0 and MODE 1 is `ctrl2_n`. `ctrl1_n` then has no effect.
- R3: With MODE 1 (preset only), the selected control line low sets `q` to all ones without a clock edge.
- R4: With MODE 2, `ctrl1_n` low clears and `ctrl2_n` low presets. When both are low, `q` is zero.
- R5: With MODE 3, `ctrl1_n` low copies `ld_data` into `q` at once. `ctrl2_n` low clears, and the clear overrides the load.
- R6: With MODE 4, `ctrl1_n` low copies `ld_data` into `q` at once. `ctrl2_n` low presets, and the preset overrides the load.
- R7: With MODE 5 (load only), `ctrl1_n` low copies `ld_data` into `q` at once. `ctrl2_n` has no effect.
- R8: With both control lines high, a rising `clk` edge with `en` high stores `d`, and one with `en` low leaves `q` unchanged. Raising a control line never changes `q`.
- R9: MODE encodings 6 and 7 behave exactly as MODE 0.
- R10: While an asynchronous control is active, a rising clock edge with `en` high does not replace the forced value with `d`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the synchronous data path |
| en | input | 1 | Clock enable; high lets a rising edge store `d` |
| d | input | WIDTH | Synchronous data word |
| ctrl1_n | input | 1 | Active-low control line one; its role depends on the mode |
| ctrl2_n | input | 1 | Active-low control line two; its role depends on the mode |
| ld_data | input | WIDTH | Word copied by the asynchronous load |
| q | output | WIDTH | Register contents |

## Verification
The register contents are the only state, and they appear directly on `q`. A wrong decode of a mode or a wrong choice of line therefore shows in the same time step as the control line falls. The bench checks `q` within a few nanoseconds of each control edge. A fault in the clocked path or in the priority over the clock shows one rising edge later. The bench samples at the following falling edge. All mode encodings and both line choices run side by side on one set of stimulus, so a fault that affects only one variant stands out against the others.

// File: rtl/async_ctl_pkg.sv
package async_ctl_pkg;

    typedef enum logic [2:0] {
        AC_CLR      = 3'd0,
        AC_PRE      = 3'd1,
        AC_CLR_PRE  = 3'd2,
        AC_LD_CLR   = 3'd3,
        AC_LD_PRE   = 3'd4,
        AC_LD_ONLY  = 3'd5
    } ac_mode_e;

    typedef struct packed {
        logic clr_n;
        logic pre_n;
        logic ald_n;
    } ac_lines_t;

    // Encodings 6 and 7 fall back to clear-only.
    function automatic ac_mode_e resolve_mode(logic [2:0] raw);
        case (raw)
            3'd1:    return AC_PRE;
            3'd2:    return AC_CLR_PRE;
            3'd3:    return AC_LD_CLR;
            3'd4:    return AC_LD_PRE;
            3'd5:    return AC_LD_ONLY;
            default: return AC_CLR;
        endcase
    endfunction

endpackage

// File: rtl/ac_decode.sv
module ac_decode
    import async_ctl_pkg::*;
#(
    parameter logic [2:0] MODE         = 3'd0,
    parameter bit         CTRL2_IS_CLR = 1'b0
) (
    input  logic      ctrl1_n,
    input  logic      ctrl2_n,
    output ac_lines_t lines
);
    localparam ac_mode_e EFF_MODE = resolve_mode(MODE);

    logic single_n;
    assign single_n = CTRL2_IS_CLR ? ctrl2_n : ctrl1_n;

    always_comb begin
        lines = '{clr_n: 1'b1, pre_n: 1'b1, ald_n: 1'b1};
        unique case (EFF_MODE)
            AC_CLR:     lines.clr_n = single_n;
            AC_PRE:     lines.pre_n = single_n;
            AC_CLR_PRE: begin
                lines.clr_n = ctrl1_n;
                lines.pre_n = ctrl2_n;
            end
            AC_LD_CLR:  begin
                lines.ald_n = ctrl1_n;
                lines.clr_n = ctrl2_n;
            end
            AC_LD_PRE:  begin
                lines.ald_n = ctrl1_n;
                lines.pre_n = ctrl2_n;
            end
            AC_LD_ONLY: lines.ald_n = ctrl1_n;
            default:    lines.clr_n = single_n;
        endcase
    end

endmodule

// File: rtl/ac_cell.sv
module ac_cell (
    input  logic clk,
    input  logic en,
    input  logic d,
    input  logic ld,
    input  logic clr_n,
    input  logic pre_n,
    input  logic ald_n,
    output logic q
);
    // Priority: clear, preset, asynchronous load, clocked path.
    always_ff @(posedge clk or negedge clr_n or negedge pre_n or negedge ald_n) begin
        if (!clr_n)
            q <= 1'b0;
        else if (!pre_n)
            q <= 1'b1;
        else if (!ald_n)
            q <= ld;
        else if (en)
            q <= d;
    end

    // R8: an enabled edge with no async control active stores d
    a_r8_capture: assert property (@(posedge clk) disable iff (!clr_n || !pre_n || !ald_n)
        ($past(en) && $past(clr_n && pre_n && ald_n)) |-> (q == $past(d)));

endmodule

// File: rtl/async_ctl_reg.sv
module async_ctl_reg
    import async_ctl_pkg::*;
#(
    parameter int         WIDTH        = 8,
    parameter logic [2:0] MODE         = 3'd0,
    parameter bit         CTRL2_IS_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    input  logic             ctrl1_n,
    input  logic             ctrl2_n,
    input  logic [WIDTH-1:0] ld_data,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = WIDTH - 1;

    ac_lines_t lines;

    ac_decode #(
        .MODE         (MODE),
        .CTRL2_IS_CLR (CTRL2_IS_CLR)
    ) u_decode (
        .ctrl1_n (ctrl1_n),
        .ctrl2_n (ctrl2_n),
        .lines   (lines)
    );

    logic clr_n, pre_n, ald_n;
    assign clr_n = lines.clr_n;
    assign pre_n = lines.pre_n;
    assign ald_n = lines.ald_n;

    for (genvar b = 0; b <= LAST; b++) begin : g_bit
        ac_cell u_cell (
            .clk   (clk),
            .en    (en),
            .d     (d[b]),
            .ld    (ld_data[b]),
            .clr_n (clr_n),
            .pre_n (pre_n),
            .ald_n (ald_n),
            .q     (q[b])
        );
    end

    // R1, R4, R5: an active clear holds the whole word at zero
    a_r1_clear_zero: assert property (@(negedge clk)
        !clr_n |-> (q == '0));

    // R3, R6: a preset without clear holds all ones
    a_r3_preset_ones: assert property (@(negedge clk) disable iff (!clr_n)
        !pre_n |-> (q == '1));

    // R5, R7: an unopposed load shows the load word
    a_r7_load_copy: assert property (@(negedge clk) disable iff (!clr_n || !pre_n)
        !ald_n |-> (q == ld_data));

endmodule

// File: tb/async_ctl_reg_test.sv
module async_ctl_reg_test;

    localparam int NI = 10;   // 0..7 = MODE with line one, 8/9 = MODE 0/1 with line two

    logic       clk = 1'b0;
    logic       en = 1'b1;
    logic [7:0] d = 8'h5A;
    logic [7:0] ld = 8'h3C;
    logic       c1 = 1'b0;
    logic       c2 = 1'b0;
    logic [7:0] qv [NI];
    logic [7:0] prev [NI];

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    for (genvar i = 0; i < NI; i++) begin : g_m
        async_ctl_reg #(
            .WIDTH        (8),
            .MODE         (i < 8 ? i[2:0] : (i - 8) & 3'h7),
            .CTRL2_IS_CLR (i >= 8)
        ) uut (
            .clk     (clk),
            .en      (en),
            .d       (d),
            .ctrl1_n (c1),
            .ctrl2_n (c2),
            .ld_data (ld),
            .q       (qv[i])
        );
    end

    // {ctrl1_n, ctrl2_n, ld_data, d}
    localparam logic [17:0] VEC [0:5] = '{
        {1'b0, 1'b1, 8'hA5, 8'h11},
        {1'b1, 1'b0, 8'hC3, 8'h22},
        {1'b0, 1'b0, 8'h96, 8'h44},
        {1'b1, 1'b1, 8'h5A, 8'h88},
        {1'b1, 1'b0, 8'h0F, 8'h7E},
        {1'b0, 1'b1, 8'hF0, 8'h01}
    };

    function automatic string req_of(int idx);
        int m = (idx < 8) ? idx : idx - 8;
        if (idx >= 8)  return "R2";
        case (m)
            0:       return "R1";
            1:       return "R3";
            2:       return "R4";
            3:       return "R5";
            4:       return "R6";
            5:       return "R7";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [7:0] model(int idx, logic a1, logic a2,
                                         logic [7:0] lw, logic [7:0] old);
        int   m = (idx < 8) ? idx : idx - 8;
        logic one = (idx >= 8) ? !a2 : !a1;
        logic kc = 1'b0, kp = 1'b0, kl = 1'b0;
        case (m)
            1: kp = one;
            2: begin kc = !a1; kp = !a2; end
            3: begin kl = !a1; kc = !a2; end
            4: begin kl = !a1; kp = !a2; end
            5: kl = !a1;
            default: kc = one;
        endcase
        if (kc)      return 8'h00;
        else if (kp) return 8'hFF;
        else if (kl) return lw;
        return old;
    endfunction

    task automatic check(string req, int idx, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s inst %0d: got %h expected %h", req, idx, act, exp);
        end
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R10: both lines low across an enabled edge; d must not win
        @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            prev[i] = model(i, 1'b0, 1'b0, 8'h3C, 8'hxx);
            check("R10", i, qv[i], prev[i]);
        end
        en = 1'b0;
        #2 c1 = 1'b1; c2 = 1'b1;
        #2;
        for (int i = 0; i < NI; i++) check("R8", i, qv[i], prev[i]);

        for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            en = 1'b0;
            @(negedge clk);
            ld = VEC[v][15:8];
            #2 c1 = VEC[v][17]; c2 = VEC[v][16];
            #2;
            for (int i = 0; i < NI; i++) begin
                prev[i] = model(i, c1, c2, ld, prev[i]);
                check(req_of(i), i, qv[i], prev[i]);
            end
            #2 c1 = 1'b1; c2 = 1'b1;
            #2;
            for (int i = 0; i < NI; i++) check("R8", i, qv[i], prev[i]);
            @(negedge clk);
            for (int i = 0; i < NI; i++) check("R8", i, qv[i], prev[i]);
            en = 1'b1;
            d  = VEC[v][7:0];
            @(negedge clk);
            for (int i = 0; i < NI; i++) begin
                prev[i] = VEC[v][7:0];
                check("R8", i, qv[i], prev[i]);
            end
            en = 1'b0;
        end

        // R10: line one held low across enabled edge, then released
        @(negedge clk);
        @(negedge clk);
        ld = 8'h69;
        d  = 8'hE7;
        #2 c1 = 1'b0;
        en = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            prev[i] = model(i, 1'b0, 1'b1, 8'h69, prev[i]);
            check((i == 8 || i == 9 || i == 2) ? "R10" : "R10", i, qv[i],
                  (i == 8 || i == 9) ? 8'hE7 : prev[i]);
        end
        en = 1'b0;
        c1 = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule